// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Shadow Capture

This block keeps time of day in packed BCD inside a 32-byte register file that a host reaches through a simple word-aligned bus port. A fast tick input is divided by a prescaler, and every overflow advances the hundredths byte. Carries then ripple through seconds, minutes, hours and day. Month, year and the remaining bytes are plain storage that the counter never touches.

A host write to the command byte with its top bit set copies the current seconds, minutes, hours, day and month into five shadow bytes. The copy is blocked while the top bit of the control byte is set. Software can then read a coherent time stamp while the live counters keep running.

The bus has no back-pressure. Every request is taken in the cycle it is presented. A read answers exactly one cycle later with `bus_rvalid_o` high. Writes complete in one cycle.

Top module: `bcd_rtc`

## Requirements
- R1: The prescaler is cleared by reset. The hundredths byte (index 0x05) advances by one BCD count on the clock edge that takes the PRE_DIV-th tick (default 100), counted since reset or since the previous advance.
- R2: An increment whose low digit is 9 sets the low digit to 0 and raises the high digit by one (0x09 becomes 0x10, 0x19 becomes 0x20).
- R3: When hundredths advances from 0x99, it becomes 0x00 and seconds (index 0x06) advances by one.
- R4: Seconds and minutes (index 0x07) advance from 0x59 to 0x00 and carry into the next field, minutes and hours respectively.
- R5: Hours (index 0x08) advance from 0x23 to 0x00 and carry into day (index 0x09).
- R6: Day advances from 0x31 to 0x01. Month (0x0A) and year (0x0B) are never changed by the counter.
- R7: The register index is bus_addr_i[6:2], and the two low address bits are ignored. A write stores only bus_wdata_i[7:0]. All 32 bytes can be written and read.
- R8: A read presents the addressed byte, zero-extended to 32 bits, on bus_rdata_o. The data appears one cycle after the request, with bus_rvalid_o high in that cycle only.
- R9: A write to index 0x04 whose data has bit 7 set, made while bit 7 of index 0x00 is clear, copies seconds, minutes, hours, day and month into indices 0x19, 0x1A, 0x1B, 0x1C and 0x1D. The copied values are those held before that write's clock edge.
- R10: No copy occurs when bit 7 of index 0x00 is set or when the written bit 7 is clear. Indices 0x19 to 0x1D are then left unchanged.
- R11: If a host write and a counter advance target the same byte on the same edge, the host value is stored. The carry that the counter computed from the old value still reaches the next field.
- R12: Reset clears all 32 bytes and bus_rvalid_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base tick, one count per cycle when high |
| bus_sel_i | input | 1 | Bus request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Byte address; index = bits [6:2] |
| bus_wdata_i | input | 32 | Write data; only [7:0] is kept |
| bus_rdata_o | output | 32 | Read data, zero-extended byte |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the request |

## Verification
Results fall due on fixed cycles:
- A read's data and valid flag appear on the edge after the request.
- A write, a snapshot copy or a counter advance shows in the register file on the edge that takes it.
- A counter advance lands on the edge carrying the hundredth tick.

The bench drives every input on the falling edge. It samples read results on the falling edge that follows the request, so each sample lands half a cycle after the edge that produced the value. Tick runs always total multiples of PRE_DIV. This lets the bench know the prescaler phase exactly, including when it lines up a host write with the advancing edge.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int unsigned NUM_FIELDS = 5;     // hundredths .. day
  localparam int unsigned IDX_CTRL   = 'h00;
  localparam int unsigned IDX_CMD    = 'h04;
  localparam int unsigned IDX_HUND   = 'h05;  // fields follow contiguously
  localparam int unsigned IDX_MONTH  = 'h0A;
  localparam int unsigned IDX_YEAR   = 'h0B;
  localparam int unsigned IDX_SNAP   = 'h19;  // shadow of seconds .. month
  localparam int unsigned SNAP_COUNT = 5;

  typedef logic [7:0] bcd_t;

  // Final value of each field before it wraps
  function automatic bcd_t field_last(input int unsigned f);
    case (f)
      0:       return 8'h99;
      1, 2:    return 8'h59;
      3:       return 8'h23;
      default: return 8'h31;
    endcase
  endfunction

  // Value a field takes after wrapping
  function automatic bcd_t field_first(input int unsigned f);
    return (f == 4) ? 8'h01 : 8'h00;
  endfunction

  // One-count packed BCD increment
  function automatic bcd_t bcd_inc(input bcd_t v);
    bcd_t r;
    if (v[3:0] >= 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = v[7:4] + 4'd1;
    end else begin
      r[3:0] = v[3:0] + 4'd1;
      r[7:4] = v[7:4];
    end
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic step_o
);
  localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign step_o = tick_i && (cnt_q == CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (step_o)   cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);
  assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> cnt_q == '0);
  assert_cnt_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_carry_chain.sv
module rtc_carry_chain
  import bcd_rtc_pkg::*;
(
  input  logic                        step_i,
  input  logic [NUM_FIELDS-1:0][7:0]  cur_i,
  output logic [NUM_FIELDS-1:0][7:0]  nxt_o,
  output logic [NUM_FIELDS-1:0]       upd_o
);
  logic [NUM_FIELDS:0] carry;
  assign carry[0] = step_i;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam bcd_t LAST  = field_last(f);
    localparam bcd_t FIRST = field_first(f);
    logic wrap;
    assign wrap         = (cur_i[f] == LAST);
    assign upd_o[f]     = carry[f];
    assign nxt_o[f]     = wrap ? FIRST : bcd_inc(cur_i[f]);
    assign carry[f+1]   = carry[f] && wrap;
  end

  always_comb begin
    for (int f = 1; f < NUM_FIELDS; f++)
      assert_chain_order_R3: assert (!upd_o[f] || upd_o[f-1]);
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic                        rd_en_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [7:0]                  wdata_i,
  input  logic [NUM_FIELDS-1:0]       upd_i,
  input  logic [NUM_FIELDS-1:0][7:0]  nxt_i,
  output logic [NUM_FIELDS-1:0][7:0]  cur_o,
  output logic [7:0]                  rdata_o,
  output logic                        rvalid_o
);
  logic [7:0] mem_q [NUM_REGS];
  logic       snap_fire;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cur
    assign cur_o[f] = mem_q[IDX_HUND + f];
  end

  assign snap_fire = wr_en_i && (idx_i == IDX_W'(IDX_CMD)) && wdata_i[7]
                     && !mem_q[IDX_CTRL][7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else begin
      for (int f = 0; f < NUM_FIELDS; f++)
        if (upd_i[f]) mem_q[IDX_HUND + f] <= nxt_i[f];
      if (snap_fire) begin
        for (int s = 0; s < SNAP_COUNT; s++)
          mem_q[IDX_SNAP + s] <= mem_q[IDX_HUND + 1 + s];
      end
      if (wr_en_i) mem_q[idx_i] <= wdata_i;   // host wins
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= mem_q[idx_i];
    end
  end

  // Checker state: last host write
  logic             chk_wr_vld;
  logic [IDX_W-1:0] chk_wr_idx;
  logic [7:0]       chk_wr_dat;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_wr_vld <= 1'b0;
      chk_wr_idx <= '0;
      chk_wr_dat <= '0;
    end else begin
      chk_wr_vld <= wr_en_i;
      chk_wr_idx <= idx_i;
      chk_wr_dat <= wdata_i;
    end
  end

  assert_host_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr_vld |-> mem_q[chk_wr_idx] == chk_wr_dat);
  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rvalid_o);
  assert_no_stray_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rvalid_o);
  assert_snap_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snap_fire |=> mem_q[IDX_SNAP] == $past(mem_q[IDX_HUND+1]));
  assert_hund_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i[0] && mem_q[IDX_HUND] == 8'h99 && !(wr_en_i && idx_i == IDX_W'(IDX_HUND)))
    |=> mem_q[IDX_HUND] == 8'h00);
  assert_month_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && idx_i == IDX_W'(IDX_MONTH)) |=> $stable(mem_q[IDX_MONTH]));
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PRE_DIV  = 100,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned ADDR_W  = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o
);
  logic                       step;
  logic [NUM_FIELDS-1:0][7:0] cur, nxt;
  logic [NUM_FIELDS-1:0]      upd;
  logic [7:0]                 rbyte;

  rtc_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .step_o (step)
  );

  rtc_carry_chain u_chain (
    .step_i (step),
    .cur_i  (cur),
    .nxt_o  (nxt),
    .upd_o  (upd)
  );

  rtc_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (bus_sel_i && bus_wr_i),
    .rd_en_i  (bus_sel_i && !bus_wr_i),
    .idx_i    (bus_addr_i[ADDR_W-1:2]),
    .wdata_i  (bus_wdata_i[7:0]),
    .upd_i    (upd),
    .nxt_i    (nxt),
    .cur_o    (cur),
    .rdata_o  (rbyte),
    .rvalid_o (bus_rvalid_o)
  );

  assign bus_rdata_o = {{(DATA_W-8){1'b0}}, rbyte};

  assert_rdata_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[DATA_W-1:8] == '0);
endmodule

// File: tb/bcd_rtc_bench.sv
`timescale 1ns/1ps
module bcd_rtc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_sel_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [6:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        bus_rvalid_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bcd_rtc u_bcd_rtc (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .bus_rvalid_o(bus_rvalid_o)
  );

  // preset {hund,sec,min,hour,day} then expected after one advance
  localparam logic [79:0] VEC [8] = '{
    80'h00_00_00_00_01__01_00_00_00_01,
    80'h09_00_00_00_01__10_00_00_00_01,
    80'h99_10_00_00_01__00_11_00_00_01,
    80'h99_59_05_00_01__00_00_06_00_01,
    80'h99_59_59_09_02__00_00_00_10_02,
    80'h99_59_59_23_15__00_00_00_00_16,
    80'h99_59_59_23_31__00_00_00_00_01,
    80'h99_59_59_23_09__00_00_00_00_10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [31:0] d, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1;
    bus_addr_i = {5'(idx), lo}; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input int idx, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = {5'(idx), 2'b00};
    @(negedge clk);
    bus_sel_i = 1'b0;
    d = bus_rdata_o; v = bus_rvalid_o;
  endtask

  task automatic read_check(input string tag, input int idx, input logic [7:0] exp);
    logic [31:0] d; logic v;
    bus_read(idx, d, v);
    check(tag, {31'd0, v}, 32'd1);
    check(tag, d, {24'd0, exp});
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d; logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    check("R12 rvalid after reset", {31'd0, bus_rvalid_o}, 32'd0);
    read_check("R12 hundredths reset", 5, 8'h00);
    read_check("R12 snapshot reset", 'h19, 8'h00);
    // R1 exact prescaler period from reset
    run_ticks(99);
    read_check("R1 no advance after 99 ticks", 5, 8'h00);
    run_ticks(1);
    read_check("R1 advance on 100th tick", 5, 8'h01);
    // Table walk: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < 8; k++) begin
      for (int f = 0; f < 5; f++) bus_write(5 + f, {24'd0, VEC[k][79-8*f -: 8]});
      run_ticks(100);
      for (int f = 0; f < 5; f++)
        read_check($sformatf("R2 R3 R4 R5 R6 vector %0d field %0d", k, f),
                   5 + f, VEC[k][39-8*f -: 8]);
    end
    // R6 month and year untouched across full rollover
    bus_write('h0A, 32'h12); bus_write('h0B, 32'h99);
    bus_write(5, 32'h99); bus_write(6, 32'h59); bus_write(7, 32'h59);
    bus_write(8, 32'h23); bus_write(9, 32'h31);
    run_ticks(100);
    read_check("R6 day wrap", 9, 8'h01);
    read_check("R6 month held", 'h0A, 8'h12);
    read_check("R6 year held", 'h0B, 8'h99);
    // R7 low address bits ignored, only low byte kept; R8 zero extension
    bus_write('h10, 32'hABCD_EF5A, 2'b11);
    read_check("R7 R8 masked write", 'h10, 8'h5A);
    for (int i = 'h11; i < 32; i++) bus_write(i, 32'h40 + i);
    for (int i = 'h11; i < 32; i++) read_check("R7 full window", i, 8'(8'h40 + i));
    // R8 valid only for the read cycle
    @(negedge clk);
    check("R8 rvalid idle", {31'd0, bus_rvalid_o}, 32'd0);
    // R9 snapshot
    bus_write(6, 32'h12); bus_write(7, 32'h34); bus_write(8, 32'h21);
    bus_write(9, 32'h07); bus_write('h0A, 32'h11);
    bus_write(0, 32'h00); bus_write(4, 32'h80);
    read_check("R9 snap sec", 'h19, 8'h12);
    read_check("R9 snap min", 'h1A, 8'h34);
    read_check("R9 snap hour", 'h1B, 8'h21);
    read_check("R9 snap day", 'h1C, 8'h07);
    read_check("R9 snap month", 'h1D, 8'h11);
    read_check("R9 command byte stored", 4, 8'h80);
    // R10 blocked by control bit, and by clear command bit
    bus_write(6, 32'h55);
    bus_write(0, 32'h80); bus_write(4, 32'h80);
    read_check("R10 blocked by control", 'h19, 8'h12);
    bus_write(0, 32'h00); bus_write(4, 32'h7F);
    read_check("R10 no copy without bit7", 'h19, 8'h12);
    // R11 host write collides with advance
    bus_write(5, 32'h99); bus_write(6, 32'h10);
    run_ticks(99);
    @(negedge clk);
    tick_i = 1'b1; bus_sel_i = 1'b1; bus_wr_i = 1'b1;
    bus_addr_i = {5'd5, 2'b00}; bus_wdata_i = 32'h77;
    @(negedge clk);
    tick_i = 1'b0; bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    read_check("R11 host value wins", 5, 8'h77);
    read_check("R11 carry still taken", 6, 8'h11);
    bus_read(5, d, v);
    check("R8 repeat read", d, 32'h77);
    finish_run();
  end
endmodule